// File: doc/BRIEF.md
# Tuner Synthesizer Configuration Slave

This block is a write-only two-wire serial slave that keeps the settings of a tuner's frequency synthesizer. It watches the serial clock and data lines through a synchronizer running on the system clock. It matches a seven-bit device address whose two low bits come from a hardware select input, and acknowledges the bytes addressed to it. It then sorts the data that follows into one of two register pairs. The most significant bit of the first data byte picks the pair.

One pair holds the loop divider: a 10-bit main count and a 5-bit swallow count. The other pair holds the loop controls and the band switches: charge-pump current, charge-pump disable, tuning-voltage disable, the 2-bit reference ratio select, the gain step and four band-switch enables. A pair reaches the outputs only when its second byte arrives. A transfer that is broken off part-way therefore leaves the running configuration untouched. A host can keep retuning with short three-byte commands once the control pair has been set. The data line is open-drain and is modelled as an input plus an active-high pull-down enable.

Top module: `tpll_cfg_slave`

## Requirements
- R1: The slave acknowledges an address byte only when it equals {1,1,0,0,0,addr_sel[1],addr_sel[0],0}. Any other address, and any byte with the read bit set, is not acknowledged. The data bytes that follow such an address are not acknowledged and change no output.
- R2: A pair whose first byte has bit 7 = 0 is a divider pair. main_cnt = {first[6:0], second[7:5]} and swallow_cnt = second[4:0].
- R3: A pair whose first byte has bit 7 = 1 is a control pair. From the first byte: cp_hi_cur = bit 6, gain_low = bit 5, cp_off = bit 4, ref_sel = bits 2:1, vt_off = bit 0; bit 3 is ignored. From the second byte: band_en = bits 3:0; bits 7:4 are ignored.
- R4: Outputs change only when the second byte of a pair completes. If a transfer is cut by STOP or by a repeated START after the first byte of a pair, the previous values stay in force.
- R5: A transfer made of the address and a divider pair updates only main_cnt and swallow_cnt; every control and band output keeps its value.
- R6: A repeated START followed by a matching address begins a new, valid transfer without an intervening STOP.
- R7: While rst_n is low, every configuration output is 0 (all band switches off) and sda_oe is 0.
- R8: After an accepted address, every further data byte is acknowledged. Bytes beyond the second of a transfer are ignored until the next START.
- R9: A band-switch output is 1 exactly when its bit in the last committed control pair is 1.
- R10: An SDA change is taken as START (falling) or STOP (rising) only while SCL is high on two successive synchronized samples. An SDA change in the same sample as an SCL fall is data.
- R11: sda_oe asserts only after the eighth SCL fall of an acknowledged byte, while SCL is low. It releases at the ninth SCL fall and is 0 outside acknowledge slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (after the open-drain wire) |
| addr_sel | input | 2 | Hardware select for the two low address bits |
| sda_oe | output | 1 | Pull the data line low (acknowledge) when 1 |
| main_cnt | output | 10 | Main divider count |
| swallow_cnt | output | 5 | Swallow counter count |
| cp_hi_cur | output | 1 | High charge-pump current selected |
| cp_off | output | 1 | Charge pump disabled |
| vt_off | output | 1 | Tuning-voltage output disabled |
| gain_low | output | 1 | Reduced-gain setting |
| ref_sel | output | 2 | Reference divider ratio select |
| band_en | output | 4 | Band-switch enables, one per band |

## Verification
Two events can share one system-clock sample. One is an SCL falling edge. The other is an SDA transition, which could look like a START or STOP if sampled carelessly. The bench sends a whole transfer in a mode where every new data bit is driven on the same clock edge that drops SCL, so both changes reach the synchronizer together. It judges the result by the acknowledge pattern and by the exact divider values committed: a false START would reset the byte count and lose the pair, and a false STOP would return the slave to idle and stop the acknowledges.

// File: rtl/tpll_pkg.sv
package tpll_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned MAIN_W  = 10;
  localparam int unsigned SWAL_W  = 5;
  localparam int unsigned BAND_W  = 4;
  localparam int unsigned REF_W   = 2;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned FIXED_W = 7 - SEL_W;
  localparam logic [FIXED_W-1:0] ADDR_FIXED = 5'b11000;

  typedef enum logic [1:0] {
    LK_IDLE,
    LK_RECV,
    LK_ACK,
    LK_SKIP
  } link_state_t;

  typedef enum logic {
    PAIR_DIV,
    PAIR_CTL
  } pair_kind_t;

  typedef struct packed {
    logic [MAIN_W-1:0] main_cnt;
    logic [SWAL_W-1:0] swal_cnt;
  } div_cfg_t;

  typedef struct packed {
    logic              cp_hi;
    logic              gain_low;
    logic              cp_off;
    logic [REF_W-1:0]  ref_sel;
    logic              vt_off;
    logic [BAND_W-1:0] band;
  } ctl_cfg_t;

endpackage

// File: rtl/tpll_line_sync.sv
module tpll_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  // idle bus level is high on both lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // a frame marker needs SCL high on both samples that bracket the SDA edge
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/tpll_link_rx.sv
module tpll_link_rx
  import tpll_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sda_s,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_det,
  input  logic                 stop_det,
  input  logic [SEL_W-1:0]     addr_sel,
  output logic                 sda_oe,
  output logic                 frame_start,
  output logic                 byte_vld,
  output logic [BYTE_W-1:0]    byte_dat
);

  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  link_state_t       state_q, state_n;
  logic [CNT_W-1:0]  bit_cnt_q, bit_cnt_n;
  logic [BYTE_W-1:0] shreg_q, shreg_n;
  logic              is_addr_q, is_addr_n;
  logic              addressed_q, addressed_n;
  logic              oe_q, oe_n;
  logic              addr_hit;

  assign addr_hit = (shreg_q[BYTE_W-1:1] == {ADDR_FIXED, addr_sel}) && !shreg_q[0];

  always_comb begin
    state_n     = state_q;
    bit_cnt_n   = bit_cnt_q;
    shreg_n     = shreg_q;
    is_addr_n   = is_addr_q;
    addressed_n = addressed_q;
    oe_n        = oe_q;
    frame_start = 1'b0;
    byte_vld    = 1'b0;
    if (start_det) begin
      state_n     = LK_RECV;
      bit_cnt_n   = '0;
      is_addr_n   = 1'b1;
      addressed_n = 1'b0;
      oe_n        = 1'b0;
      frame_start = 1'b1;
    end else if (stop_det) begin
      state_n     = LK_IDLE;
      addressed_n = 1'b0;
      oe_n        = 1'b0;
    end else begin
      unique case (state_q)
        LK_RECV: begin
          if (scl_rise && bit_cnt_q != LAST_BIT) begin
            shreg_n   = {shreg_q[BYTE_W-2:0], sda_s};
            bit_cnt_n = bit_cnt_q + 1'b1;
          end else if (scl_fall && bit_cnt_q == LAST_BIT) begin
            bit_cnt_n = '0;
            state_n   = LK_ACK;
            if (is_addr_q) begin
              is_addr_n   = 1'b0;
              addressed_n = addr_hit;
              oe_n        = addr_hit;
            end else begin
              oe_n     = 1'b1;
              byte_vld = 1'b1;
            end
          end
        end
        LK_ACK: begin
          if (scl_fall) begin
            oe_n    = 1'b0;
            state_n = addressed_q ? LK_RECV : LK_SKIP;
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= LK_IDLE;
      bit_cnt_q   <= '0;
      shreg_q     <= '0;
      is_addr_q   <= 1'b0;
      addressed_q <= 1'b0;
      oe_q        <= 1'b0;
    end else begin
      state_q     <= state_n;
      bit_cnt_q   <= bit_cnt_n;
      shreg_q     <= shreg_n;
      is_addr_q   <= is_addr_n;
      addressed_q <= addressed_n;
      oe_q        <= oe_n;
    end
  end

  assign sda_oe   = oe_q;
  assign byte_dat = shreg_q;

endmodule

// File: rtl/tpll_frame_dec.sv
module tpll_frame_dec
  import tpll_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_dat,
  output logic              commit_div,
  output logic              commit_ctl,
  output div_cfg_t          div_next,
  output ctl_cfg_t          ctl_next
);

  logic [1:0]        idx_q, idx_n;
  logic [BYTE_W-2:0] stage_q, stage_n;
  pair_kind_t        kind_q, kind_n;

  always_comb begin
    idx_n      = idx_q;
    stage_n    = stage_q;
    kind_n     = kind_q;
    commit_div = 1'b0;
    commit_ctl = 1'b0;
    if (frame_start) begin
      idx_n = 2'd0;
    end else if (byte_vld) begin
      unique case (idx_q)
        2'd0: begin
          stage_n = byte_dat[BYTE_W-2:0];
          kind_n  = byte_dat[BYTE_W-1] ? PAIR_CTL : PAIR_DIV;
          idx_n   = 2'd1;
        end
        2'd1: begin
          commit_div = (kind_q == PAIR_DIV);
          commit_ctl = (kind_q == PAIR_CTL);
          idx_n      = 2'd2;
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= 2'd2;
      stage_q <= '0;
      kind_q  <= PAIR_DIV;
    end else begin
      idx_q   <= idx_n;
      stage_q <= stage_n;
      kind_q  <= kind_n;
    end
  end

  // field placement of the two pairs
  assign div_next.main_cnt = {stage_q, byte_dat[BYTE_W-1:SWAL_W]};
  assign div_next.swal_cnt = byte_dat[SWAL_W-1:0];
  assign ctl_next.cp_hi    = stage_q[6];
  assign ctl_next.gain_low = stage_q[5];
  assign ctl_next.cp_off   = stage_q[4];
  assign ctl_next.ref_sel  = stage_q[2:1];
  assign ctl_next.vt_off   = stage_q[0];
  assign ctl_next.band     = byte_dat[BAND_W-1:0];

endmodule

// File: rtl/tpll_cfg_bank.sv
module tpll_cfg_bank
  import tpll_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     commit_div,
  input  logic     commit_ctl,
  input  div_cfg_t div_next,
  input  ctl_cfg_t ctl_next,
  output div_cfg_t div_cfg,
  output ctl_cfg_t ctl_cfg
);

  div_cfg_t div_q, div_n;
  ctl_cfg_t ctl_q, ctl_n;

  always_comb begin
    div_n = commit_div ? div_next : div_q;
    ctl_n = commit_ctl ? ctl_next : ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ctl_q <= '0;
    end else begin
      div_q <= div_n;
      ctl_q <= ctl_n;
    end
  end

  assign div_cfg = div_q;
  assign ctl_cfg = ctl_q;

endmodule

// File: rtl/tpll_cfg_slave.sv
module tpll_cfg_slave
  import tpll_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [SEL_W-1:0]  addr_sel,
  output logic              sda_oe,
  output logic [MAIN_W-1:0] main_cnt,
  output logic [SWAL_W-1:0] swallow_cnt,
  output logic              cp_hi_cur,
  output logic              cp_off,
  output logic              vt_off,
  output logic              gain_low,
  output logic [REF_W-1:0]  ref_sel,
  output logic [BAND_W-1:0] band_en
);

  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              frame_start, byte_vld;
  logic [BYTE_W-1:0] byte_dat;
  logic              commit_div, commit_ctl;
  div_cfg_t          div_next, div_cfg;
  ctl_cfg_t          ctl_next, ctl_cfg;

  tpll_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  tpll_link_rx u_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .addr_sel   (addr_sel),
    .sda_oe     (sda_oe),
    .frame_start(frame_start),
    .byte_vld   (byte_vld),
    .byte_dat   (byte_dat)
  );

  tpll_frame_dec u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .byte_vld   (byte_vld),
    .byte_dat   (byte_dat),
    .commit_div (commit_div),
    .commit_ctl (commit_ctl),
    .div_next   (div_next),
    .ctl_next   (ctl_next)
  );

  tpll_cfg_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_div(commit_div),
    .commit_ctl(commit_ctl),
    .div_next  (div_next),
    .ctl_next  (ctl_next),
    .div_cfg   (div_cfg),
    .ctl_cfg   (ctl_cfg)
  );

  assign main_cnt    = div_cfg.main_cnt;
  assign swallow_cnt = div_cfg.swal_cnt;
  assign cp_hi_cur   = ctl_cfg.cp_hi;
  assign cp_off      = ctl_cfg.cp_off;
  assign vt_off      = ctl_cfg.vt_off;
  assign gain_low    = ctl_cfg.gain_low;
  assign ref_sel     = ctl_cfg.ref_sel;
  assign band_en     = ctl_cfg.band;

endmodule

// File: rtl/tpll_cfg_slave_chk.sv
module tpll_cfg_slave_chk
  import tpll_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              commit_div,
  input logic              commit_ctl,
  input logic [MAIN_W-1:0] main_cnt,
  input logic [SWAL_W-1:0] swallow_cnt,
  input logic              cp_hi_cur,
  input logic [BAND_W-1:0] band_en
);

  // R11: acknowledge pull-down starts only while the sampled clock is low
  a_r11_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R11: acknowledge pull-down ends only while the sampled clock is low
  a_r11_oe_fall_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_s);

  // R4: divider outputs move only in the cycle after a divider commit
  a_r4_div_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(main_cnt) && $stable(swallow_cnt)) |-> $past(commit_div));

  // R5: control and band outputs move only after a control commit
  a_r5_ctl_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(band_en) && $stable(cp_hi_cur)) |-> $past(commit_ctl));

  // R7: reset holds every output cleared
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      a_r7_reset_clear: assert (main_cnt == '0 && swallow_cnt == '0 &&
                                band_en == '0 && !cp_hi_cur && !sda_oe);
    end
  end

endmodule

bind tpll_cfg_slave tpll_cfg_slave_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_s      (scl_s),
  .sda_oe     (sda_oe),
  .commit_div (commit_div),
  .commit_ctl (commit_ctl),
  .main_cnt   (main_cnt),
  .swallow_cnt(swallow_cnt),
  .cp_hi_cur  (cp_hi_cur),
  .band_en    (band_en)
);

// File: tb/sim_tpll_cfg_slave.sv
`timescale 1ns/1ps
module sim_tpll_cfg_slave;

  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m;
  logic       sda_m;
  logic       sda_line;
  logic [1:0] addr_sel;
  logic       sda_oe;
  logic [9:0] main_cnt;
  logic [4:0] swallow_cnt;
  logic       cp_hi_cur, cp_off, vt_off, gain_low;
  logic [1:0] ref_sel;
  logic [3:0] band_en;

  int n_chk  = 0;
  int n_fail = 0;
  bit timeout = 1'b0;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  tpll_cfg_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel(addr_sel), .sda_oe(sda_oe), .main_cnt(main_cnt),
    .swallow_cnt(swallow_cnt), .cp_hi_cur(cp_hi_cur), .cp_off(cp_off),
    .vt_off(vt_off), .gain_low(gain_low), .ref_sel(ref_sel), .band_en(band_en)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_n(Q);
    scl_m = 1'b1; wait_n(Q);
    sda_m = 1'b0; wait_n(Q);
    scl_m = 1'b0; wait_n(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_n(Q);
    scl_m = 1'b1; wait_n(Q);
    sda_m = 1'b1; wait_n(2*Q);
  endtask

  task automatic bus_byte(input logic [7:0] b, input bit coin, output bit acked);
    sda_m = b[7]; wait_n(Q);
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b1; wait_n(2*Q);
      scl_m = 1'b0;
      if (coin) sda_m = (i > 0) ? b[i-1] : 1'b1;
      wait_n(Q);
      if (!coin) sda_m = (i > 0) ? b[i-1] : 1'b1;
      wait_n(Q);
    end
    scl_m = 1'b1; wait_n(Q);
    acked = (sda_line == 1'b0);
    wait_n(Q);
    scl_m = 1'b0; wait_n(2*Q);
  endtask

  // sends n bytes after a START; optional STOP; returns ack mask
  task automatic xfer(input logic [7:0] d [6], input int n, input bit coin,
                      input bit do_stop, output logic [5:0] acks);
    bit a;
    acks = '0;
    bus_start();
    for (int k = 0; k < n; k++) begin
      bus_byte(d[k], coin, a);
      acks[k] = a;
    end
    if (do_stop) bus_stop();
  endtask

  task automatic t_reset();
    chk("R7", "main_cnt", main_cnt, 0);
    chk("R7", "swallow_cnt", swallow_cnt, 0);
    chk("R7", "band_en", band_en, 0);
    chk("R7", "ctl bits", {cp_hi_cur, cp_off, vt_off, gain_low, ref_sel}, 0);
    chk("R7", "sda_oe", sda_oe, 0);
  endtask

  task automatic t_divider();
    logic [7:0] d [6] = '{8'hC4, 8'h5A, 8'hB3, 0, 0, 0};
    logic [5:0] acks;
    xfer(d, 3, 1'b0, 1'b1, acks);
    chk("R2", "acks", acks, 6'b000111);
    chk("R2", "main_cnt", main_cnt, 10'h2D5);
    chk("R2", "swallow_cnt", swallow_cnt, 5'h13);
    chk("R11", "sda_oe idle", sda_oe, 0);
  endtask

  task automatic t_control();
    logic [7:0] d [6] = '{8'hC4, 8'hD5, 8'hFA, 0, 0, 0};
    logic [5:0] acks;
    xfer(d, 3, 1'b0, 1'b1, acks);
    chk("R3", "acks", acks, 6'b000111);
    chk("R3", "cp_hi_cur", cp_hi_cur, 1);
    chk("R3", "gain_low", gain_low, 0);
    chk("R3", "cp_off", cp_off, 1);
    chk("R3", "ref_sel", ref_sel, 2'b10);
    chk("R3", "vt_off", vt_off, 1);
    chk("R9", "band_en", band_en, 4'b1010);
    chk("R3", "main_cnt kept", main_cnt, 10'h2D5);
  endtask

  task automatic t_abort();
    logic [7:0] d1 [6] = '{8'hC4, 8'h12, 0, 0, 0, 0};
    logic [7:0] d2 [6] = '{8'hC4, 8'h80, 0, 0, 0, 0};
    logic [5:0] acks;
    xfer(d1, 2, 1'b0, 1'b1, acks);
    chk("R4", "main_cnt after cut", main_cnt, 10'h2D5);
    chk("R4", "swallow after cut", swallow_cnt, 5'h13);
    xfer(d2, 2, 1'b0, 1'b1, acks);
    chk("R4", "band after cut", band_en, 4'b1010);
    chk("R4", "cp_hi after cut", cp_hi_cur, 1);
  endtask

  task automatic t_three_byte();
    logic [7:0] d [6] = '{8'hC4, 8'h03, 8'h40, 0, 0, 0};
    logic [5:0] acks;
    xfer(d, 3, 1'b0, 1'b1, acks);
    chk("R5", "main_cnt", main_cnt, 10'h01A);
    chk("R5", "swallow_cnt", swallow_cnt, 0);
    chk("R5", "band kept", band_en, 4'b1010);
    chk("R5", "ctl kept", {cp_hi_cur, cp_off, vt_off, gain_low, ref_sel}, 6'b111010);
  endtask

  task automatic t_bad_addr();
    logic [7:0] d1 [6] = '{8'hC6, 8'h7F, 8'hFF, 0, 0, 0};
    logic [7:0] d2 [6] = '{8'hC5, 8'h7F, 8'hFF, 0, 0, 0};
    logic [7:0] d3 [6] = '{8'hC2, 8'h00, 8'h21, 0, 0, 0};
    logic [5:0] acks;
    xfer(d1, 3, 1'b0, 1'b1, acks);
    chk("R1", "other address acks", acks, 0);
    chk("R1", "main_cnt kept", main_cnt, 10'h01A);
    xfer(d2, 3, 1'b0, 1'b1, acks);
    chk("R1", "read bit acks", acks, 0);
    chk("R1", "main_cnt kept read", main_cnt, 10'h01A);
    addr_sel = 2'b01;
    xfer(d3, 3, 1'b0, 1'b1, acks);
    chk("R1", "new select acks", acks, 6'b000111);
    chk("R1", "new select main", main_cnt, 10'h001);
    addr_sel = 2'b10;
  endtask

  task automatic t_repstart();
    logic [7:0] d1 [6] = '{8'hC4, 8'h01, 0, 0, 0, 0};
    logic [7:0] d2 [6] = '{8'hC4, 8'h7F, 8'hFF, 0, 0, 0};
    logic [5:0] acks;
    xfer(d1, 2, 1'b0, 1'b0, acks);
    xfer(d2, 3, 1'b0, 1'b1, acks);
    chk("R6", "acks", acks, 6'b000111);
    chk("R6", "main_cnt", main_cnt, 10'h3FF);
    chk("R6", "swallow_cnt", swallow_cnt, 5'h1F);
  endtask

  task automatic t_extra();
    logic [7:0] d [6] = '{8'hC4, 8'h81, 8'h05, 8'h00, 8'hFF, 0};
    logic [5:0] acks;
    xfer(d, 5, 1'b0, 1'b1, acks);
    chk("R8", "acks", acks, 6'b011111);
    chk("R8", "band_en", band_en, 4'b0101);
    chk("R8", "ctl bits", {cp_hi_cur, cp_off, vt_off, gain_low, ref_sel}, 6'b001000);
    chk("R8", "main_cnt kept", main_cnt, 10'h3FF);
  endtask

  task automatic t_coincide();
    logic [7:0] d [6] = '{8'hC4, 8'h2A, 8'h5C, 0, 0, 0};
    logic [5:0] acks;
    xfer(d, 3, 1'b1, 1'b1, acks);
    chk("R10", "acks", acks, 6'b000111);
    chk("R10", "main_cnt", main_cnt, 10'h152);
    chk("R10", "swallow_cnt", swallow_cnt, 5'h1C);
    chk("R11", "sda_oe idle", sda_oe, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    scl_m = 1'b1;
    sda_m = 1'b1;
    addr_sel = 2'b10;
    fork
      begin
        wait_n(5);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        wait_n(4);
        t_divider();
        t_control();
        t_abort();
        t_three_byte();
        t_bad_addr();
        t_repstart();
        t_extra();
        t_coincide();
      end
      begin
        repeat (150000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual expired expected done");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule